// File: doc/BRIEF.md
# Two-Master Local Bus Arbiter with Timeout Capture

The block shares one local bus between two masters. Each master raises a request; the arbiter gives the bus to one of them and holds the grant until the addressed target signals completion. A programmable control register picks between a fixed-priority scheme and a fair scheme that alternates on contested cycles. It also sets which master is preferred when a tie has to be broken by configuration alone.

A watchdog runs while a grant is held. If the target does not complete within the timeout window, the arbiter raises a one-cycle timeout, takes the grant back and records the address of the stalled access. It also sets a timeout flag and a lock flag for the guilty master in the error status register. While any lock flag is set, the captured address stays frozen. Software clears the flags by writing ones to them. The grant machine has three named states: `ST_IDLE` (no owner), `ST_OWN0` (master 0 holds the bus) and `ST_OWN1` (master 1 holds the bus). There are four transitions. IDLE→OWN0 and IDLE→OWN1 happen on an arbitration win. OWN0→IDLE and OWN1→IDLE happen on completion or on timeout.

Top module: `lba_arbiter2`

## Requirements
- R1: Grants are one-hot or zero and are registered: a request seen in the idle state gives a grant on the next clock edge. An owner is always followed by at least one idle cycle, so the grant never passes directly from one master to the other.
- R2: The control register is at offset 0x5C. Data bit 31 is the mode: 0 means fixed, 1 means fair. Data bits 30:29 are the order code: 00 prefers master 0 and 01 prefers master 1. In fixed mode the preferred master wins when both masters request.
- R3: Writing order code 10 or 11 stores and reads back 00 and behaves as 00. Control bits 28:0 always read zero.
- R4: In fair mode, a contested request goes to the master that lost the most recent contested grant. Until the first contested grant after reset, the order code decides.
- R5: A master that is not requesting is never granted. A lone requester gets the bus whatever the mode or order.
- R6: The watchdog allows 16 grant cycles. If completion is not signalled by the 16th, `timeout` is high in that 16th cycle and the grant drops at the next edge. A completion ends the grant at the next edge with no timeout.
- R7: The error address register is at offset 0x58 and is read-only, so writes to it change nothing. On a timeout with no lock flag set, it captures the owner's address.
- R8: The error status register is at offset 0x50, with bit 31 = master 0 timeout, bit 30 = master 1 timeout, bit 29 = master 0 lock and bit 28 = master 1 lock. The other bits read zero. A timeout sets both the timeout flag and the lock flag of the owner.
- R9: Writing 1 to a status bit clears it, and a simultaneous set wins. While any lock flag is set, the error address stays frozen. After all lock flags are cleared, the next timeout captures again.
- R10: After reset, no grant is active, all three registers read zero, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m0_req | input | 1 | Master 0 bus request |
| m1_req | input | 1 | Master 1 bus request |
| m0_addr | input | 32 | Master 0 access address |
| m1_addr | input | 32 | Master 1 access address |
| m0_gnt | output | 1 | Master 0 bus grant |
| m1_gnt | output | 1 | Master 1 bus grant |
| xfer_done | input | 1 | Target completion for the current owner |
| timeout | output | 1 | One-cycle watchdog expiry |
| reg_addr | input | 8 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
Arbitration is driven four ways: both masters at once, and each master alone, under each order code, a reserved code and fair mode. This separates the order decision from the lone-requester rule and from the alternation history. Fair mode is also started from a fresh reset to show that the first tie follows the order code rather than stale history. Stalled grants are produced back to back from both masters with different addresses, interleaved with partial and full flag clears. This separates capture, freeze and re-arm of the error address. A grant closed by completion is contrasted with a stalled grant to pin the exact 16-cycle window.

// File: rtl/lba_pkg.sv
package lba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN0 = 2'd1,
        ST_OWN1 = 2'd2
    } own_state_e;

    localparam logic [7:0] OFS_STAT  = 8'h50;
    localparam logic [7:0] OFS_EADDR = 8'h58;
    localparam logic [7:0] OFS_CTRL  = 8'h5C;

    localparam logic [1:0] ORD_M0_FIRST = 2'b00;
    localparam logic [1:0] ORD_M1_FIRST = 2'b01;
endpackage

// File: rtl/lba_grant_fsm.sv
module lba_grant_fsm
    import lba_pkg::*;
#(
    parameter int NUM_M = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_M-1:0] req,
    input  logic             fair,
    input  logic             pref_m1,
    input  logic             release_i,
    output logic [NUM_M-1:0] gnt
);
    own_state_e state_q, state_d;
    logic hist_valid_q, hist_m1_q;
    logic contested, pick_m1;

    always_comb begin
        contested = req[0] & req[1];
        if (contested) begin
            pick_m1 = (fair && hist_valid_q) ? ~hist_m1_q : pref_m1;
        end else begin
            pick_m1 = req[1];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (|req) state_d = pick_m1 ? ST_OWN1 : ST_OWN0;
            ST_OWN0: if (release_i) state_d = ST_IDLE;
            ST_OWN1: if (release_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_valid_q <= 1'b0;
            hist_m1_q    <= 1'b0;
        end else if (state_q == ST_IDLE && contested) begin
            hist_valid_q <= 1'b1;
            hist_m1_q    <= pick_m1;
        end
    end

    always_comb begin
        gnt = '0;
        unique case (state_q)
            ST_IDLE: gnt = '0;
            ST_OWN0: gnt[0] = 1'b1;
            ST_OWN1: gnt[1] = 1'b1;
            default: gnt = '0;
        endcase
    end

    // R5: a grant only rises for a master that was requesting
    a_r5_rise0_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt[0]) |-> $past(req[0]));
    a_r5_rise1_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt[1]) |-> $past(req[1]));
    // R1: ownership never swaps without an idle cycle
    a_r1_no_swap01: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[0] |=> !gnt[1]);
    a_r1_no_swap10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[1] |=> !gnt[0]);
endmodule

// File: rtl/lba_watchdog.sv
module lba_watchdog #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic done,
    output logic expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (busy) cnt_q <= cnt_q + 1'b1;
        else           cnt_q <= '0;
    end

    assign expire = busy && !done && (cnt_q == CW'(LIMIT - 1));

    // R6: the owner can never outlast the window
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < CW'(LIMIT)));
endmodule

// File: rtl/lba_regs.sv
module lba_regs
    import lba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 8,
    localparam int B_MODE = DATA_W - 1,
    localparam int B_OHI  = DATA_W - 2,
    localparam int B_OLO  = DATA_W - 3,
    localparam int B_T0   = DATA_W - 1,
    localparam int B_T1   = DATA_W - 2,
    localparam int B_L0   = DATA_W - 3,
    localparam int B_L1   = DATA_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tmo,
    input  logic              tmo_m1,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic              fair,
    output logic              pref_m1
);
    logic              mode_q;
    logic [1:0]        ord_q;
    logic [1:0]        tflag_q, lflag_q;
    logic [ADDR_W-1:0] ear_q;
    logic [1:0]        owner_set, tclr, lclr;
    logic              wr_ctrl, wr_stat;
    logic              unused_wbits;

    assign wr_ctrl = reg_we && (reg_addr == REG_AW'(OFS_CTRL));
    assign wr_stat = reg_we && (reg_addr == REG_AW'(OFS_STAT));
    assign unused_wbits = ^reg_wdata[B_L1-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            ord_q  <= ORD_M0_FIRST;
        end else if (wr_ctrl) begin
            mode_q <= reg_wdata[B_MODE];
            ord_q  <= reg_wdata[B_OHI] ? ORD_M0_FIRST : reg_wdata[B_OHI:B_OLO];
        end
    end

    assign fair    = mode_q;
    assign pref_m1 = (ord_q == ORD_M1_FIRST);

    always_comb begin
        owner_set = tmo ? (tmo_m1 ? 2'b10 : 2'b01) : 2'b00;
        tclr      = wr_stat ? {reg_wdata[B_T1], reg_wdata[B_T0]} : 2'b00;
        lclr      = wr_stat ? {reg_wdata[B_L1], reg_wdata[B_L0]} : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tflag_q <= '0;
            lflag_q <= '0;
        end else begin
            tflag_q <= (tflag_q & ~tclr) | owner_set;
            lflag_q <= (lflag_q & ~lclr) | owner_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ear_q <= '0;
        else if (tmo && lflag_q == 0) ear_q <= cap_addr;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_CTRL)) begin
            reg_rdata[B_MODE]      = mode_q;
            reg_rdata[B_OHI:B_OLO] = ord_q;
        end else if (reg_addr == REG_AW'(OFS_EADDR)) begin
            reg_rdata = DATA_W'(ear_q);
        end else if (reg_addr == REG_AW'(OFS_STAT)) begin
            reg_rdata[B_T0] = tflag_q[0];
            reg_rdata[B_T1] = tflag_q[1];
            reg_rdata[B_L0] = lflag_q[0];
            reg_rdata[B_L1] = lflag_q[1];
        end
    end

    // R9: a held lock freezes the captured address
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (|lflag_q) |=> $stable(ear_q));
    // R7: only a timeout may move the captured address
    a_r7_only_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo |=> $stable(ear_q));
    // R8: a timeout marks the owner's flags
    a_r8_flags_m0: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !tmo_m1) |=> (tflag_q[0] && lflag_q[0]));
    a_r8_flags_m1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && tmo_m1) |=> (tflag_q[1] && lflag_q[1]));
endmodule

// File: rtl/lba_arbiter2.sv
module lba_arbiter2
    import lba_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int REG_AW     = 8,
    parameter int TMO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m0_req,
    input  logic              m1_req,
    input  logic [ADDR_W-1:0] m0_addr,
    input  logic [ADDR_W-1:0] m1_addr,
    output logic              m0_gnt,
    output logic              m1_gnt,
    input  logic              xfer_done,
    output logic              timeout,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [1:0]        gnt;
    logic              fair, pref_m1, expire, busy;
    logic [ADDR_W-1:0] cap_addr;

    assign busy     = |gnt;
    assign cap_addr = gnt[1] ? m1_addr : m0_addr;

    lba_grant_fsm #(.NUM_M(2)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req({m1_req, m0_req}),
        .fair(fair), .pref_m1(pref_m1),
        .release_i(xfer_done | expire), .gnt(gnt)
    );

    lba_watchdog #(.LIMIT(TMO_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .busy(busy), .done(xfer_done), .expire(expire)
    );

    lba_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tmo(expire), .tmo_m1(gnt[1]), .cap_addr(cap_addr),
        .fair(fair), .pref_m1(pref_m1)
    );

    assign m0_gnt  = gnt[0];
    assign m1_gnt  = gnt[1];
    assign timeout = expire;

    // R6: an expiry always takes the bus back at the next edge
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !(m0_gnt || m1_gnt));
    // R6: completion never coincides with a timeout
    a_r6_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !timeout);
endmodule

// File: tb/tb_lba_arbiter2.sv
module tb_lba_arbiter2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m0_req = 1'b0, m1_req = 1'b0;
    logic [31:0] m0_addr = 32'h1000_0A00, m1_addr = 32'h2000_0B00;
    logic        m0_gnt, m1_gnt, xfer_done = 1'b0, timeout;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    logic [1:0] prev_g = 2'b00;
    bit ended = 0;

    always #2.5 clk = ~clk;

    lba_arbiter2 dut (
        .clk(clk), .rst_n(rst_n), .m0_req(m0_req), .m1_req(m1_req),
        .m0_addr(m0_addr), .m1_addr(m1_addr), .m0_gnt(m0_gnt), .m1_gnt(m1_gnt),
        .xfer_done(xfer_done), .timeout(timeout), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: each new grant is compared against the scoreboard queue
    always @(negedge clk) begin
        logic [1:0] g;
        g = {m1_gnt, m0_gnt};
        if (!rst_n) prev_g = 2'b00;
        else begin
            if (prev_g == 2'b00 && g != 2'b00) begin
                if (exp_q.size() == 0) check("R5 unexpected grant", {30'd0, g}, 32'd0);
                else check("R1/R2/R4/R5 grant owner", {30'd0, g}, 32'd1 << exp_q.pop_front());
            end
            prev_g = g;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    // driver: pushes the expected owner, raises requests, ends by done or stall
    task automatic round(input logic r0, input logic r1, input int owner,
                         input bit stall, output int hi, output int tmo);
        exp_q.push_back(owner);
        hi = 0; tmo = 0;
        @(negedge clk);
        m0_req = r0; m1_req = r1;
        @(negedge clk);
        check("R1 grant one edge after request", {31'd0, m0_gnt | m1_gnt}, 32'd1);
        while (!(m0_gnt || m1_gnt)) @(negedge clk);
        m0_req = 1'b0; m1_req = 1'b0;
        if (!stall) begin
            xfer_done = 1'b1; hi = 1;
            #1 if (timeout) tmo++;
            @(negedge clk);
            xfer_done = 1'b0;
        end else begin
            while (m0_gnt || m1_gnt) begin
                hi++;
                if (timeout) tmo++;
                @(negedge clk);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        finish_run();
    end

    initial begin
        int hi, tmo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        @(negedge clk);
        check("R10 no grant after reset", {30'd0, m1_gnt, m0_gnt}, 32'd0);
        rd("R10 ctrl reset", 8'h5C, 32'h0);
        rd("R10 eaddr reset", 8'h58, 32'h0);
        rd("R10 status reset", 8'h50, 32'h0);
        rd("R10 unmapped offset", 8'h54, 32'h0);

        // R2 fixed, order 00
        round(1, 1, 0, 0, hi, tmo);
        check("R6 done ends grant without timeout", tmo, 0);
        round(0, 1, 1, 0, hi, tmo);                    // R5 lone requester
        wr(8'h5C, 32'h2000_0000);
        rd("R2 ctrl readback order 01", 8'h5C, 32'h2000_0000);
        round(1, 1, 1, 0, hi, tmo);                    // R2 order 01
        round(1, 0, 0, 0, hi, tmo);                    // R5 lone m0 under order 01
        wr(8'h5C, 32'h5FFF_FFFF);
        rd("R3 reserved order reads 00, low bits zero", 8'h5C, 32'h0);
        round(1, 1, 0, 0, hi, tmo);                    // R3 behaves as 00

        // R6/R7/R8 first stall by master 0
        round(1, 0, 0, 1, hi, tmo);
        check("R6 grant length on stall", hi, 16);
        check("R6 single timeout pulse", tmo, 1);
        rd("R8 status after m0 timeout", 8'h50, 32'hA000_0000);
        rd("R7 captured m0 address", 8'h58, 32'h1000_0A00);
        wr(8'h58, 32'hDEAD_BEEF);
        rd("R7 eaddr write ignored", 8'h58, 32'h1000_0A00);

        // R9 second stall by master 1 while locked
        m1_addr = 32'h2000_0C40;
        round(0, 1, 1, 1, hi, tmo);
        rd("R8 status both masters", 8'h50, 32'hF000_0000);
        rd("R9 eaddr frozen by lock", 8'h58, 32'h1000_0A00);
        wr(8'h50, 32'h2000_0000);
        rd("R9 partial clear", 8'h50, 32'hD000_0000);
        m0_addr = 32'h1000_0E80;
        round(1, 0, 0, 1, hi, tmo);
        rd("R9 still frozen by remaining lock", 8'h58, 32'h1000_0A00);
        wr(8'h50, 32'hF000_0000);
        rd("R9 full clear", 8'h50, 32'h0);
        m1_addr = 32'h2000_0FF0;
        round(0, 1, 1, 1, hi, tmo);
        rd("R9 capture re-armed", 8'h58, 32'h2000_0FF0);

        // R4 fair mode from a fresh reset, order 01
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        wr(8'h5C, 32'hA000_0000);
        rd("R2 ctrl fair readback", 8'h5C, 32'hA000_0000);
        round(1, 1, 1, 0, hi, tmo);                    // R4 first tie by order
        round(1, 1, 0, 0, hi, tmo);                    // R4 alternates
        round(1, 1, 1, 0, hi, tmo);
        round(1, 0, 0, 0, hi, tmo);                    // R5 lone, no history change
        round(1, 1, 0, 0, hi, tmo);                    // R4 last contested was m1

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule